// File: doc/BRIEF.md
# Multi-Valued Logic Register with Set and Reset

This block is a bank of edge-triggered storage cells for a simulation-style logic system in which every wire carries one of nine levels instead of a plain bit. Each control input (set, reset, clock) and each data bit arrives as a 4-bit level code. The block folds every code into one of four classes (uninitialised U, 0, 1, unknown X), works out what kind of change the logical clock made since the previous sample, and applies a fixed priority to decide each output bit. Every output bit is a 2-bit class code.

The block is sampled by a free-running system clock `clk`; the logical clock `clock_lvl` is just another level-coded input. It is compared against the class stored on the previous system cycle. The parameter `ACTIVE_LOW` chooses whether set and reset are asserted by class 1 (default) or class 0. Uncertain control or clock situations resolve to X, so uninitialised and unknown values propagate instead of being hidden.

Top module: `mvl_register`

## Requirements
- R1: While `rst_n` is low every output bit reads 00 (U), and the stored previous clock class is U.
- R2: Level codes are 0=U, 1=X, 2=0, 3=1, 4=Z, 5=W, 6=L, 7=H, 8=don't-care, 9..15 unused. They fold to classes as follows: L to 0, H to 1, U to U, and X, Z, W, don't-care and unused codes to X. Output class codes are 00=U, 01=0, 10=1, 11=X.
- R3: If set or reset is in class U, every output bit becomes U. This overrides every other rule.
- R4: If set is active and neither control is U, every output bit becomes 1, whatever reset is.
- R5: If reset is active and set is inactive, every output bit becomes 0.
- R6: If neither control is U, set is not active, and reset is not inactive or set is not inactive, with the case of R5 excluded, every output bit becomes X. This covers reset active with set X, both controls X, and one control inactive with the other X.
- R7: With both controls inactive, a clock change from class 0 to class 1 loads each data bit's class into its output bit.
- R8: With both controls inactive, a clock change from 0 to X or U, or from X or U to 1, drives every output bit to X.
- R9: With both controls inactive, every other clock change leaves the output unchanged. This includes any change to 0, any change away from 1, no change at all, and changes between X and U.
- R10: With `ACTIVE_LOW` = 1, class 0 is the active level and class 1 the inactive level for both set and reset. All other rules keep their priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system sampling clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| set_lvl | input | 4 | Set control level code |
| reset_lvl | input | 4 | Reset control level code |
| clock_lvl | input | 4 | Logical clock level code |
| d_lvl | input | 4*WIDTH | Data level codes, bit i in [4i+3:4i] |
| q | output | 2*WIDTH | Output class codes, bit i in [2i+1:2i] |

## Verification
Every result is due exactly one system cycle after its inputs are presented. The inputs are sampled at a rising edge of `clk`, the output register updates at that same edge, and the previous clock class updates alongside it. The bench drives on the falling edge and compares at the next falling edge, so each comparison covers exactly one sampled input set. The bench's model of the previous clock class advances in the same step. Two instances run side by side. The low-active instance receives the same clock and data with the control levels mirrored, so both instances must produce identical outputs.

// File: rtl/mvl_register.sv
module mvl_register #(
  parameter int WIDTH      = 4,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           set_lvl,
  input  logic [3:0]           reset_lvl,
  input  logic [3:0]           clock_lvl,
  input  logic [4*WIDTH-1:0]   d_lvl,
  output logic [2*WIDTH-1:0]   q
);
  localparam logic [1:0] C_U = 2'b00;
  localparam logic [1:0] C_0 = 2'b01;
  localparam logic [1:0] C_1 = 2'b10;
  localparam logic [1:0] C_X = 2'b11;
  localparam logic [1:0] C_ON  = ACTIVE_LOW ? C_0 : C_1;
  localparam logic [1:0] C_OFF = ACTIVE_LOW ? C_1 : C_0;

  typedef enum logic [2:0] {DO_HOLD, DO_LOAD, DO_U, DO_ONE, DO_ZERO, DO_X} action_t;

  function automatic logic [1:0] fold(input logic [3:0] lvl);
    case (lvl)
      4'd0:       fold = C_U;
      4'd2, 4'd6: fold = C_0;
      4'd3, 4'd7: fold = C_1;
      default:    fold = C_X;
    endcase
  endfunction

  logic [1:0] set_c, rst_c, clk_c, clk_prev;
  action_t    act;

  assign set_c = fold(set_lvl);
  assign rst_c = fold(reset_lvl);
  assign clk_c = fold(clock_lvl);

  logic clk_unk, prev_unk;
  assign clk_unk  = (clk_c == C_U) || (clk_c == C_X);
  assign prev_unk = (clk_prev == C_U) || (clk_prev == C_X);

  always_comb begin
    if (set_c == C_U || rst_c == C_U)            act = DO_U;
    else if (set_c == C_ON)                      act = DO_ONE;
    else if (rst_c == C_ON && set_c == C_OFF)    act = DO_ZERO;
    else if (rst_c != C_OFF || set_c != C_OFF)   act = DO_X;
    else if (clk_prev == C_0 && clk_c == C_1)    act = DO_LOAD;
    else if ((clk_prev == C_0 && clk_unk) ||
             (prev_unk && clk_c == C_1))         act = DO_X;
    else                                         act = DO_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= C_U;
    else        clk_prev <= clk_c;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] nxt;
    always_comb begin
      case (act)
        DO_U:    nxt = C_U;
        DO_ONE:  nxt = C_1;
        DO_ZERO: nxt = C_0;
        DO_X:    nxt = C_X;
        DO_LOAD: nxt = fold(d_lvl[4*i +: 4]);
        default: nxt = q[2*i +: 2];
      endcase
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[2*i +: 2] <= C_U;
      else        q[2*i +: 2] <= nxt;
    end
  end
endmodule

// File: rtl/mvl_register_chk.sv
module mvl_register_chk #(
  parameter int WIDTH      = 4,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         set_lvl,
  input logic [3:0]         reset_lvl,
  input logic [3:0]         clock_lvl,
  input logic [2*WIDTH-1:0] q
);
  function automatic logic [1:0] cls(input logic [3:0] v);
    if (v == 4'd0)                     return 2'b00;
    else if (v == 4'd2 || v == 4'd6)   return 2'b01;
    else if (v == 4'd3 || v == 4'd7)   return 2'b10;
    else                               return 2'b11;
  endfunction

  logic [1:0] s, r, k, on_lvl, off_lvl;
  assign s = cls(set_lvl);
  assign r = cls(reset_lvl);
  assign k = cls(clock_lvl);
  assign on_lvl  = ACTIVE_LOW ? 2'b01 : 2'b10;
  assign off_lvl = ACTIVE_LOW ? 2'b10 : 2'b01;

  // R3
  ctrl_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s == 2'b00 || r == 2'b00) |=> q == {WIDTH{2'b00}});
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s == on_lvl && r != 2'b00) |=> q == {WIDTH{2'b10}});
  // R5
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r == on_lvl && s == off_lvl) |=> q == {WIDTH{2'b01}});
  // R6
  reset_set_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r == on_lvl && s == 2'b11) |=> q == {WIDTH{2'b11}});
  // R9
  clock_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s == off_lvl && r == off_lvl && k == 2'b01) |=> q == $past(q));
endmodule

bind mvl_register mvl_register_chk #(.WIDTH(WIDTH), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_lvl(set_lvl), .reset_lvl(reset_lvl),
  .clock_lvl(clock_lvl), .q(q)
);

// File: tb/tb_mvl_register.sv
module tb_mvl_register;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] set_hi, rst_hi, set_lo, rst_lo, kl;
  logic [4*W-1:0] d;
  logic [2*W-1:0] q_hi, q_lo;
  int checks = 0, fails = 0, cyc = 0;
  logic [1:0] m_prev;
  logic [2*W-1:0] m_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  mvl_register #(.WIDTH(W), .ACTIVE_LOW(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .set_lvl(set_hi), .reset_lvl(rst_hi),
    .clock_lvl(kl), .d_lvl(d), .q(q_hi));
  mvl_register #(.WIDTH(W), .ACTIVE_LOW(1'b1)) dut_lo (
    .clk(clk), .rst_n(rst_n), .set_lvl(set_lo), .reset_lvl(rst_lo),
    .clock_lvl(kl), .d_lvl(d), .q(q_lo));

  function automatic logic [1:0] cls(input logic [3:0] v);
    case (v)
      4'd0: return 2'b00;
      4'd2, 4'd6: return 2'b01;
      4'd3, 4'd7: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [3:0] mirror(input logic [3:0] v);
    case (v)
      4'd2: return 4'd3;
      4'd3: return 4'd2;
      4'd6: return 4'd7;
      4'd7: return 4'd6;
      default: return v;
    endcase
  endfunction

  function automatic logic [2*W-1:0] model(input logic [3:0] s, r, k,
      input logic [4*W-1:0] dv, input logic [1:0] pk,
      input logic [2*W-1:0] cur, output string tag);
    logic [1:0] sc, rc, kc;
    logic [2*W-1:0] ld;
    sc = cls(s); rc = cls(r); kc = cls(k);
    if (sc == 2'b00 || rc == 2'b00) begin tag = "R3"; return {W{2'b00}}; end
    if (sc == 2'b10) begin tag = "R4"; return {W{2'b10}}; end
    if (rc == 2'b10 && sc == 2'b01) begin tag = "R5"; return {W{2'b01}}; end
    if (rc != 2'b01 || sc != 2'b01) begin tag = "R6"; return {W{2'b11}}; end
    if (pk == 2'b01 && kc == 2'b10) begin
      for (int i = 0; i < W; i++) ld[2*i +: 2] = cls(dv[4*i +: 4]);
      tag = "R7/R2"; return ld;
    end
    if ((pk == 2'b01 && (kc == 2'b00 || kc == 2'b11)) ||
        ((pk == 2'b00 || pk == 2'b11) && kc == 2'b10)) begin
      tag = "R8"; return {W{2'b11}};
    end
    tag = "R9"; return cur;
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic cmp(input logic [2*W-1:0] got, exp, input string tag, input string who);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (%s): got %h expected %h", tag, who, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] s, r, k, input logic [4*W-1:0] dv);
    string tag;
    logic [2*W-1:0] exp;
    set_hi = s; rst_hi = r; set_lo = mirror(s); rst_lo = mirror(r); kl = k; d = dv;
    @(negedge clk);
    exp = model(s, r, k, dv, m_prev, m_out, tag);
    cmp(q_hi, exp, tag, "high-active");
    cmp(q_lo, exp, {tag, " R10"}, "low-active");
    m_out = exp;
    m_prev = cls(k);
  endtask

  function automatic logic [3:0] pick_ctrl();
    int v = $urandom_range(0, 19);
    if (v < 12) return (v[0]) ? 4'd6 : 4'd2;
    if (v < 17) return (v[0]) ? 4'd7 : 4'd3;
    if (v == 17) return 4'd0;
    return 4'(1 + 3 * $urandom_range(0, 1) + ($urandom_range(0, 1) ? 0 : 3));
  endfunction

  function automatic logic [3:0] pick_clk();
    if ($urandom_range(0, 3) == 0) return 4'($urandom_range(0, 15));
    return 4'(2 + $urandom_range(0, 1) + 4 * $urandom_range(0, 1));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected at most 60000", cyc);
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    set_hi = 4'd2; rst_hi = 4'd2; set_lo = 4'd3; rst_lo = 4'd3; kl = 4'd3; d = '0;
    m_prev = 2'b00; m_out = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp(q_hi, {W{2'b00}}, "R1", "high-active");
    cmp(q_lo, {W{2'b00}}, "R1 R10", "low-active");
    rst_n = 1'b1;
    // directed corners
    step(4'd6, 4'd2, 4'd2, 16'h1302);        // U->0 clock: hold (R9)
    step(4'd2, 4'd2, 4'd3, 16'h1023);        // 0->1 load: 1,0,U,X (R7)
    step(4'd2, 4'd6, 4'd7, 16'h2222);        // 1->1: hold (R9)
    step(4'd2, 4'd2, 4'd2, 16'h3333);        // 1->0: hold (R9)
    step(4'd2, 4'd2, 4'd4, 16'h3333);        // 0->X: unknown edge (R8)
    step(4'd2, 4'd2, 4'd0, 16'h3333);        // X->U: hold (R9)
    step(4'd2, 4'd2, 4'd7, 16'h2222);        // U->1: unknown edge (R8)
    step(4'd3, 4'd3, 4'd2, 16'h0000);        // set wins over reset (R4)
    step(4'd2, 4'd7, 4'd2, 16'h0000);        // reset (R5)
    step(4'd4, 4'd3, 4'd2, 16'h0000);        // reset with set X (R6)
    step(4'd0, 4'd2, 4'd2, 16'h0000);        // set U (R3)
    step(4'd3, 4'd0, 4'd2, 16'h0000);        // reset U over set (R3)
    step(4'd1, 4'd2, 4'd2, 16'h0000);        // set X, reset off (R6)
    step(4'd2, 4'd5, 4'd2, 16'h0000);        // reset X, set off (R6)
    step(4'd2, 4'd2, 4'd2, 16'h0000);
    step(4'd2, 4'd2, 4'd7, 16'h8576);        // weak codes load: 0,1,X,X (R2)
    step(4'd2, 4'd2, 4'd2, 16'h0000);
    step(4'd2, 4'd2, 4'd3, 16'hF9C4);        // unused codes load as X (R2)
    for (int n = 0; n < 3000; n++) begin
      logic [4*W-1:0] dv;
      for (int b = 0; b < W; b++) dv[4*b +: 4] = 4'($urandom_range(0, 15));
      step(pick_ctrl(), pick_ctrl(), pick_clk(), dv);
    end
    summary();
  end
endmodule